// File: doc/BRIEF.md
# GPIO Pin Mode and Output Register Block

This block holds the per-pin configuration and output state for a 54-pin general-purpose I/O port behind a simple 32-bit word-addressed register bus. Each pin owns a 3-bit mode field that makes it an input, a software-driven output, or one of six alternate functions. For alternate modes the block only tells an outside pin mux which peripheral owns the pin. It does not contain the peripherals.

Software never rewrites the output data directly. It raises pins by writing ones to a set word and lowers them by writing ones to a clear word. Zero bits in those writes leave the other pins alone, so two agents can drive different pins without a read-modify-write race. Pin inputs pass through a two-flop synchroniser and can be read back from a level word. The output latches keep their value while a pin is not an output, so switching a pin to output mode drives the last latched level at once.

Top module: `gpio_mux_regs`

## Requirements
- R1: After reset every mode field holds input (code 0). All output latches hold 0. `pin_oe`, `pin_alt_en` and `pin_alt_idx` are all zero.
- R2: The mode field of pin p sits in mode word p/10, which is word address p/10 starting at word 0, at bits (p mod 10)*3 +: 3. A write to a mode word replaces the fields of all ten pins in that word. A read of a mode word returns those fields.
- R3: Mode decode works as follows. `pin_oe[p]` is 1 only for code 1. `pin_alt_en[p]` is 1 for codes 2 to 7. The alternate index on `pin_alt_idx[3p +: 3]` is 0 for code 4, 1 for 5, 2 for 6, 3 for 7, 4 for 3 and 5 for 2. The index is 0 whenever `pin_alt_en[p]` is 0.
- R4: A write to a set word drives high the output latch of each pin whose data bit is 1. The set words are at word address 7 (byte 0x1C) for pins 0-31 and word address 8 for pins 32-53, with pin p at bit p mod 32. Bits written as 0 leave their latches unchanged. The new level is on `pin_out` right after the write edge.
- R5: A write to a clear word drives low the output latch of each pin whose data bit is 1. The clear words are at word address 10 (byte 0x28) and word address 11, with the same bit layout as the set words. Bits written as 0 have no effect.
- R6: A level word returns the synchronised pin inputs. Level words are at word address 13 (byte 0x34) for pins 0-31 and word address 14 for pins 32-53, with pin p at bit p mod 32. A change on `pin_in` needs two clock edges to reach the level word. A read issued at the first edge after the change still returns the old level.
- R7: Unused high bits read as zero and writes to them are ignored. These are bits 30-31 of every mode word, bits 12-31 of mode word 5, and bits 22-31 of the upper set, clear and level words.
- R8: `pin_out` changes only on a set or clear write. An output latch keeps its level while the pin is in any non-output mode. A later switch to output mode drives that level with `pin_oe` raised.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is 1 and holds otherwise. Set and clear words, and word addresses outside every register, read as zero.
- R10: Set and clear writes leave the mode fields unchanged, so they do not change `pin_oe` or `pin_alt_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data is in bus_rdata after the edge |
| bus_word_addr | input | 6 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Output latch levels |
| pin_oe | output | 54 | Output enable, high for output mode |
| pin_alt_en | output | 54 | Pin is owned by an alternate function |
| pin_alt_idx | output | 162 | Alternate function index, 3 bits per pin |

## Verification
The bench sweeps all eight mode codes and compares the alternate index against the scrambled table. A decoder that treated the codes as sequential would send alt4 and alt5 pins to the wrong peripheral. It writes all-ones patterns to the partial last mode word and the upper bank words, which exposes any design that stores or returns bits past pin 53. Set and clear writes with mostly zero data run against a known latch state, so a design doing read-modify-write or plain data replacement would corrupt untouched pins. The bench also reads the level word one edge after a pin change to catch a missing synchroniser stage. It latches a pin high while the pin is an input and then switches it to output, which catches a design that clears latches on a mode change.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PM_INPUT  = 3'd0,
      PM_OUTPUT = 3'd1,
      PM_ALT5   = 3'd2,
      PM_ALT4   = 3'd3,
      PM_ALT0   = 3'd4,
      PM_ALT1   = 3'd5,
      PM_ALT2   = 3'd6,
      PM_ALT3   = 3'd7
   } pin_mode_e;

   // Owner is an alternate peripheral for every code except input and output.
   function automatic logic mode_is_alt(input logic [MODE_W-1:0] code);
      return (code != PM_INPUT) && (code != PM_OUTPUT);
   endfunction

   // Maps the scrambled code to the peripheral index seen by the pin mux.
   function automatic logic [MODE_W-1:0] mode_alt_index(input logic [MODE_W-1:0] code);
      logic [MODE_W-1:0] idx;
      case (pin_mode_e'(code))
         PM_ALT0: idx = 3'd0;
         PM_ALT1: idx = 3'd1;
         PM_ALT2: idx = 3'd2;
         PM_ALT3: idx = 3'd3;
         PM_ALT4: idx = 3'd4;
         PM_ALT5: idx = 3'd5;
         default: idx = 3'd0;
      endcase
      return idx;
   endfunction

endpackage

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
   import gpio_mux_pkg::*;
#(
   parameter int NUM_PINS      = 54,
   parameter int PINS_PER_WORD = 10,
   parameter int DATA_W        = 32,
   parameter int WORDS         = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
   parameter int FIELD_BITS    = PINS_PER_WORD * MODE_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [31:0]                  sel,
   input  logic [FIELD_BITS-1:0]        wr_fields,
   output logic [DATA_W-1:0]            rd_word,
   output logic [NUM_PINS-1:0]          pin_oe,
   output logic [NUM_PINS-1:0]          pin_alt_en,
   output logic [NUM_PINS*MODE_W-1:0]   pin_alt_idx
);

   logic [MODE_W-1:0]     mode_q [NUM_PINS];
   logic [FIELD_BITS-1:0] img    [WORDS];
   logic [FIELD_BITS-1:0] sel_img;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PINS; p++) mode_q[p] <= PM_INPUT;
      end else if (wr_en) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (sel == 32'(p / PINS_PER_WORD))
               mode_q[p] <= wr_fields[(p % PINS_PER_WORD)*MODE_W +: MODE_W];
         end
      end
   end

   // Slots past the last pin stay zero in the read image.
   always_comb begin
      for (int w = 0; w < WORDS; w++) img[w] = '0;
      for (int p = 0; p < NUM_PINS; p++)
         img[p / PINS_PER_WORD][(p % PINS_PER_WORD)*MODE_W +: MODE_W] = mode_q[p];
   end

   always_comb begin
      sel_img = '0;
      for (int w = 0; w < WORDS; w++)
         if (sel == 32'(w)) sel_img = img[w];
   end

   if (DATA_W > FIELD_BITS) begin : g_pad
      assign rd_word = {{(DATA_W-FIELD_BITS){1'b0}}, sel_img};
   end else begin : g_nopad
      assign rd_word = sel_img;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
      assign pin_oe[p]     = (mode_q[p] == PM_OUTPUT);
      assign pin_alt_en[p] = mode_is_alt(mode_q[p]);
      assign pin_alt_idx[p*MODE_W +: MODE_W] = mode_alt_index(mode_q[p]);
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [31:0]         bank_sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] pin_out
);

   logic [NUM_PINS-1:0] set_bit;
   logic [NUM_PINS-1:0] clr_bit;
   logic [NUM_PINS-1:0] out_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_strobe
      localparam logic [31:0] BANK = 32'(p / DATA_W);
      assign set_bit[p] = set_en && (bank_sel == BANK) && wdata[p % DATA_W];
      assign clr_bit[p] = clr_en && (bank_sel == BANK) && wdata[p % DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= (out_q | set_bit) & ~clr_bit;
   end

   assign pin_out = out_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 54,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw,
   output logic [NUM_PINS-1:0] synced
);

   logic [NUM_PINS-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= raw;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign synced = stg[STAGES-1];

endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
   import gpio_mux_pkg::*;
#(
   parameter int NUM_PINS      = 54,
   parameter int PINS_PER_WORD = 10,
   parameter int DATA_W        = 32,
   parameter int WADDR_W       = 6,
   parameter int MODE_OFS      = 'h00,
   parameter int SET_OFS       = 'h1C,
   parameter int CLR_OFS       = 'h28,
   parameter int LEV_OFS       = 'h34,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [WADDR_W-1:0]         bus_word_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_PINS-1:0]        pin_in,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS-1:0]        pin_alt_en,
   output logic [NUM_PINS*MODE_W-1:0] pin_alt_idx
);

   localparam int MODE_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
   localparam int BANKS      = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int FIELD_BITS = PINS_PER_WORD * MODE_W;
   localparam int MODE_WA    = MODE_OFS / 4;
   localparam int SET_WA     = SET_OFS / 4;
   localparam int CLR_WA     = CLR_OFS / 4;
   localparam int LEV_WA     = LEV_OFS / 4;

   // Elaboration checks on the parameter set
   if (FIELD_BITS > DATA_W) begin : g_bad_pack
      $error("mode fields of one word exceed the data width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchroniser needs at least two stages");
   end
   if ((MODE_OFS % 4) != 0 || (SET_OFS % 4) != 0 || (CLR_OFS % 4) != 0 || (LEV_OFS % 4) != 0)
   begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (MODE_WA + MODE_WORDS > SET_WA || SET_WA + BANKS > CLR_WA || CLR_WA + BANKS > LEV_WA)
   begin : g_bad_map
      $error("register ranges overlap or are out of order");
   end
   if (LEV_WA + BANKS > (1 << WADDR_W)) begin : g_bad_addr
      $error("word address too narrow for the register map");
   end

   logic [31:0] widx, mode_rel, set_rel, clr_rel, lev_rel;
   logic        mode_hit, set_hit, clr_hit, lev_hit;
   logic [DATA_W-1:0] mode_rd, lev_rd;
   logic [NUM_PINS-1:0] pin_sync;

   assign widx     = 32'(bus_word_addr);
   assign mode_rel = widx - MODE_WA;
   assign set_rel  = widx - SET_WA;
   assign clr_rel  = widx - CLR_WA;
   assign lev_rel  = widx - LEV_WA;
   assign mode_hit = mode_rel < MODE_WORDS;
   assign set_hit  = set_rel  < BANKS;
   assign clr_hit  = clr_rel  < BANKS;
   assign lev_hit  = lev_rel  < BANKS;

   gpio_mode_bank #(
      .NUM_PINS(NUM_PINS), .PINS_PER_WORD(PINS_PER_WORD), .DATA_W(DATA_W),
      .WORDS(MODE_WORDS), .FIELD_BITS(FIELD_BITS)
   ) u_modes (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && mode_hit), .sel(mode_rel),
      .wr_fields(bus_wdata[FIELD_BITS-1:0]),
      .rd_word(mode_rd),
      .pin_oe(pin_oe), .pin_alt_en(pin_alt_en), .pin_alt_idx(pin_alt_idx)
   );

   gpio_out_latch #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .set_en(bus_wr && set_hit), .clr_en(bus_wr && clr_hit),
      .bank_sel(set_hit ? set_rel : clr_rel),
      .wdata(bus_wdata), .pin_out(pin_out)
   );

   gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(pin_sync)
   );

   // Level read: bank words, bits past the last pin are zero.
   always_comb begin
      lev_rd = '0;
      for (int b = 0; b < BANKS; b++) begin
         for (int i = 0; i < DATA_W; i++) begin
            if (b*DATA_W + i < NUM_PINS && lev_rel == 32'(b))
               lev_rd[i] = pin_sync[b*DATA_W + i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd) begin
         if (mode_hit)     bus_rdata <= mode_rd;
         else if (lev_hit) bus_rdata <= lev_rd;
         else              bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/gpio_mux_regs_chk.sv
module gpio_mux_regs_chk
   import gpio_mux_pkg::*;
#(
   parameter int NUM_PINS = 54,
   parameter int DATA_W   = 32,
   parameter int WADDR_W  = 6,
   parameter int MODE_OFS = 'h00,
   parameter int SET_OFS  = 'h1C,
   parameter int CLR_OFS  = 'h28,
   parameter int PINS_PER_WORD = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic                       bus_rd,
   input logic [WADDR_W-1:0]         bus_word_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [NUM_PINS-1:0]        pin_out,
   input logic [NUM_PINS-1:0]        pin_oe,
   input logic [NUM_PINS-1:0]        pin_alt_en,
   input logic [NUM_PINS*MODE_W-1:0] pin_alt_idx
);

   localparam int BANKS      = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int MODE_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

   logic [31:0] wa;
   logic        wr_set, wr_clr, wr_mode, idx_stray;
   logic [NUM_PINS-1:0] set_now, clr_now;

   assign wa      = 32'(bus_word_addr);
   assign wr_set  = bus_wr && (wa - SET_OFS/4) < BANKS;
   assign wr_clr  = bus_wr && (wa - CLR_OFS/4) < BANKS;
   assign wr_mode = bus_wr && (wa - MODE_OFS/4) < MODE_WORDS;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_exp
      assign set_now[p] = wr_set && (wa == 32'(SET_OFS/4 + p/DATA_W)) && bus_wdata[p % DATA_W];
      assign clr_now[p] = wr_clr && (wa == 32'(CLR_OFS/4 + p/DATA_W)) && bus_wdata[p % DATA_W];
   end

   always_comb begin
      idx_stray = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
         if (!pin_alt_en[p] && pin_alt_idx[p*MODE_W +: MODE_W] != '0) idx_stray = 1'b1;
   end

   // R1: outputs idle after a reset cycle
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0 && pin_oe == '0 && pin_alt_en == '0));

   // R3: a pin is never both software output and alternate owned
   p_oe_alt_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_alt_en) == '0);

   // R3: index is zero on pins that are not alternate owned
   p_idx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_stray);

   // R4: set bits are high after the write
   p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((pin_out & $past(set_now)) == $past(set_now)));

   // R5: clear bits are low after the write
   p_clr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((pin_out & $past(clr_now)) == '0));

   // R8: no set or clear write, no output change
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(pin_out));

   // R9: read data holds without a read strobe
   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R10: modes only move on a mode word write
   p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> ($stable(pin_oe) && $stable(pin_alt_en)));

endmodule

bind gpio_mux_regs gpio_mux_regs_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .WADDR_W(WADDR_W),
   .MODE_OFS(MODE_OFS), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS),
   .PINS_PER_WORD(PINS_PER_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt_en(pin_alt_en),
   .pin_alt_idx(pin_alt_idx)
);

// File: tb/gpio_mux_regs_test.sv
module gpio_mux_regs_test;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 54;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [5:0]    bus_word_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, pin_alt_en;
   logic [NP*3-1:0] pin_alt_idx;

   gpio_mux_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_alt_en(pin_alt_en), .pin_alt_idx(pin_alt_idx)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [2:0]    m_mode [NP];
   logic [NP-1:0] m_out;

   function automatic logic [2:0] want_idx(input logic [2:0] c);
      case (c)
         3'd4: return 3'd0;
         3'd5: return 3'd1;
         3'd6: return 3'd2;
         3'd7: return 3'd3;
         3'd3: return 3'd4;
         3'd2: return 3'd5;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] want_read(input logic [5:0] a);
      logic [31:0] r = '0;
      if (a < 6) begin
         for (int s = 0; s < 10; s++)
            if (int'(a)*10 + s < NP) r[s*3 +: 3] = m_mode[int'(a)*10 + s];
      end else if (a == 6'd13 || a == 6'd14) begin
         for (int b = 0; b < 32; b++)
            if ((int'(a) - 13)*32 + b < NP) r[b] = pin_in[(int'(a) - 13)*32 + b];
      end
      return r;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [191:0] act, input logic [191:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_pins(input string req);
      logic [NP-1:0]   e_oe, e_en;
      logic [NP*3-1:0] e_idx;
      for (int p = 0; p < NP; p++) begin
         e_oe[p] = (m_mode[p] == 3'd1);
         e_en[p] = (m_mode[p] >= 3'd2);
         e_idx[p*3 +: 3] = e_en[p] ? want_idx(m_mode[p]) : 3'd0;
      end
      check(req, "pin_oe", 192'(pin_oe), 192'(e_oe));
      check(req, "pin_alt_en", 192'(pin_alt_en), 192'(e_en));
      check(req, "pin_alt_idx", 192'(pin_alt_idx), 192'(e_idx));
      check(req, "pin_out", 192'(pin_out), 192'(m_out));
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_word_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a < 6) begin
         for (int s = 0; s < 10; s++)
            if (int'(a)*10 + s < NP) m_mode[int'(a)*10 + s] = d[s*3 +: 3];
      end else if (a == 6'd7 || a == 6'd8 || a == 6'd10 || a == 6'd11) begin
         for (int b = 0; b < 32; b++) begin
            int p;
            p = ((a == 6'd8 || a == 6'd11) ? 32 : 0) + b;
            if (p < NP && d[b]) m_out[p] = (a == 6'd7 || a == 6'd8);
         end
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_word_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog all requirements: actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, prev;
      logic [NP-1:0] old_pins;
      void'($urandom(32'd2024));
      for (int p = 0; p < NP; p++) m_mode[p] = 3'd0;
      m_out = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_pins("R1");
      rd(6'd0, d);  check("R1", "mode word 0", 192'(d), 192'(0));
      rd(6'd5, d);  check("R1", "mode word 5", 192'(d), 192'(0));

      // R3: every code on pin 0
      for (int c = 0; c < 8; c++) begin
         wr(6'd0, 32'(c));
         check_pins("R3");
      end
      wr(6'd0, 32'd0);

      // R2: pin 37 is word 3 slot 7
      wr(6'd3, 32'h1 << 21);
      check("R2", "pin_oe[37]", 192'(pin_oe[37]), 192'(1));
      check_pins("R2");
      wr(6'd2, 32'h2468ACE1);
      rd(6'd2, d);  check("R2", "mode word 2 readback", 192'(d), 192'(want_read(6'd2)));
      wr(6'd3, 32'd0);

      // R7: unused high bits
      wr(6'd5, 32'hFFFF_FFFF);
      rd(6'd5, d);  check("R7", "mode word 5 all ones", 192'(d), 192'(32'h0000_0FFF));
      wr(6'd0, 32'hFFFF_FFFF);
      rd(6'd0, d);  check("R7", "mode word 0 all ones", 192'(d), 192'(32'h3FFF_FFFF));
      check_pins("R7");
      for (int w = 0; w < 6; w++) wr(6'(w), 32'd0);

      // R8: latch kept while input, driven on switch to output
      wr(6'd7, 32'h20);
      check("R8", "pin_out[5] while input", 192'(pin_out[5]), 192'(1));
      check("R8", "pin_oe[5] while input", 192'(pin_oe[5]), 192'(0));
      wr(6'd0, 32'h1 << 15);
      check("R8", "pin_oe[5] after output", 192'(pin_oe[5]), 192'(1));
      check("R8", "pin_out[5] after output", 192'(pin_out[5]), 192'(1));

      // R4 / R5 / R10: zero bits leave latches, modes untouched
      wr(6'd8, 32'hFFFF_FFFF);
      check_pins("R4");
      wr(6'd7, 32'd0);
      check_pins("R4");
      wr(6'd11, 32'h0020_0000);
      check("R5", "pin_out[53] cleared", 192'(pin_out[53]), 192'(0));
      check_pins("R5");
      wr(6'd10, 32'd0);
      check_pins("R10");

      // R6: synchroniser latency and upper bank mask
      @(negedge clk); pin_in = {NP{1'b1}};
      repeat (3) @(negedge clk);
      rd(6'd14, d); check("R7", "level word 1 all ones", 192'(d), 192'(32'h003F_FFFF));
      old_pins = pin_in;
      @(negedge clk); pin_in = 54'h15_5555_AAAA_5555;
      rd(6'd13, d); check("R6", "level after one edge", 192'(d), 192'(old_pins[31:0]));
      rd(6'd13, d); check("R6", "level after two edges", 192'(d), 192'(pin_in[31:0]));

      // R9: write-only and unmapped words, hold without strobe
      rd(6'd7, d);  check("R9", "set word reads zero", 192'(d), 192'(0));
      rd(6'd11, d); check("R9", "clear word reads zero", 192'(d), 192'(0));
      rd(6'd63, d); check("R9", "unmapped reads zero", 192'(d), 192'(0));
      rd(6'd14, prev);
      repeat (2) @(negedge clk);
      check("R9", "rdata hold", 192'(bus_rdata), 192'(prev));

      // Random mix of mode, set, clear, pins and reads
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [63:0] rp;
         op = int'($urandom % 6);
         case (op)
            0: begin wr(6'($urandom % 6), $urandom); check_pins("R2"); end
            1: begin wr((($urandom % 2) != 0) ? 6'd8 : 6'd7, $urandom); check_pins("R4"); end
            2: begin wr((($urandom % 2) != 0) ? 6'd11 : 6'd10, $urandom); check_pins("R5"); end
            3: begin
               logic [5:0] a;
               a = 6'($urandom % 20);
               rd(a, d); check("R9", "random read", 192'(d), 192'(want_read(a)));
            end
            4: begin
               rp = {$urandom, $urandom};
               @(negedge clk); pin_in = rp[NP-1:0];
               repeat (3) @(negedge clk);
            end
            default: begin
               logic [5:0] a;
               a = (($urandom % 2) != 0) ? 6'd14 : 6'd13;
               rd(a, d); check("R6", "random level", 192'(d), 192'(want_read(a)));
            end
         endcase
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule